// File: doc/BRIEF.md
# Isochronous Resource Manager Lock Registers

This block keeps the four bus-resource registers that an isochronous resource manager owns: the bus manager identity, the remaining isochronous bandwidth, and two 32-bit words that together form a 64-entry channel availability bitmap. Remote nodes change these registers only through compare-and-swap lock requests. Each register interprets compare-and-swap in its own way. The identity register does a plain equality swap. The bandwidth register adds or subtracts a difference and checks for underflow and overflow. The channel words toggle only the bits that differ between the expected and new values. Channel 31, the broadcast channel (bit 0 of the high word), can never be freed.

One request is presented per cycle, already parsed from the packet: a kind (read, write or lock), a byte offset into the four-register window, an extended transaction code, a flag for a 64-bit lock, and 64-bit expected and new values. The block answers one cycle later with a one-cycle response strobe, a response code and the old value. A bus-reset input reloads every register to its power-up value.

The control is a three-state machine. ST_LOAD is entered from reset and, from any state, whenever bus_reset is high; it takes priority over everything else. ST_RESP is entered from any state when a request is present without bus_reset; it is the response cycle. ST_IDLE is entered from any state when there is neither. rsp_valid is high exactly in ST_RESP.

Top module: `irm_lock_regs`

## Requirements
- R1: After rst_n or a cycle with bus_reset high, the registers are: bus manager ID 0x3F at offset 0x0, bandwidth 4915 at offset 0x4, channels high 0xFFFFFFFE at offset 0x8, channels low 0xFFFFFFFF at offset 0xC.
- R2: A request sampled at a clock edge with bus_reset low produces rsp_valid high for exactly the following cycle. A request that coincides with bus_reset is dropped and gets no response.
- R3: A lock on the bus manager ID returns the old value. It stores the new value only if the old value equals the expected value.
- R4: For a bandwidth lock with an expected value above 0x1FFF, the register is left unchanged and the old value is returned. The new value is always masked to its low 13 bits.
- R5: A bandwidth lock with expected >= new allocates the difference. If old >= difference, the register drops by the difference and the expected value is returned. Otherwise nothing changes and the old value is returned.
- R6: A bandwidth lock with expected < new releases the difference. If old + difference < 0x2000, the register rises by that amount and the expected value is returned. Otherwise nothing changes and the old value is returned.
- R7: A channel-word lock takes the affected bits as expected XOR new. If the register matches the expected value on those bits, the bits are toggled and the expected value is returned. Otherwise the current word is returned and nothing changes.
- R8: Bit 0 of the channels-high word stays 0. A lock that tries to set it has that bit of the new value forced to 0 first.
- R9: A 64-bit lock (req_wide=1) is accepted only at offset 0x8. It runs the R7 rule on {high, low} as one 64-bit word and returns a 64-bit old value. At any other in-window offset it gives a type error.
- R10: Reads (kind 0) of the four registers return code 0 and the value zero-extended to 64 bits. Writes (kind 1) to them return type error (code 1) and change nothing.
- R11: Kind 2 is lock; only extended code 2 is compare-swap. An offset with bits [1:0] nonzero, a lock with any other extended code, or kind 3 gives a type error. An aligned offset of 0x10 or more gives an address error (code 2). Every error response carries a zero old value and changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_reset | input | 1 | Reload all registers to defaults |
| req_valid | input | 1 | Request present this cycle |
| req_kind | input | 2 | 0 read, 1 write, 2 lock, 3 reserved |
| req_addr | input | ADDR_W | Byte offset into the register window |
| req_ext | input | EXT_W | Extended transaction code (2 = compare-swap) |
| req_wide | input | 1 | 64-bit lock |
| req_arg | input | 2*REG_W | Expected value (low word for 32-bit operations) |
| req_data | input | 2*REG_W | New value (low word for 32-bit operations) |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_code | output | 2 | 0 complete, 1 type error, 2 address error |
| rsp_old | output | 2*REG_W | Returned old value |

## Verification
The bench targets the bandwidth edges: an allocation larger than what remains, a release whose sum lands exactly on 0x1FFF (accepted) or beyond it (refused), an expected value of 0x2000, and a new value with stray upper bits. A design that got these wrong would wrap the counter or report a false success. It also tries to free the broadcast channel through both the 32-bit and the 64-bit lock, and repeats a channel allocation so the second attempt must fail. A design that got these wrong would release channel 31 or grant one channel twice. Finally, it issues a lock in the same cycle as bus_reset, and sends writes, wrong extended codes and misplaced wide locks. A faulty design would answer a dropped request or let a refused access alter a register.

// File: rtl/irm_pkg.sv
package irm_pkg;
    typedef enum logic [1:0] {
        K_READ  = 2'd0,
        K_WRITE = 2'd1,
        K_LOCK  = 2'd2,
        K_RSVD  = 2'd3
    } req_kind_e;

    typedef enum logic [1:0] {
        RC_DONE = 2'd0,
        RC_TYPE = 2'd1,
        RC_ADDR = 2'd2
    } rsp_code_e;

    // Register order is decoded from offset bits [3:2]
    typedef enum logic [1:0] {
        SEL_BM  = 2'd0,
        SEL_BW  = 2'd1,
        SEL_CHI = 2'd2,
        SEL_CLO = 2'd3
    } reg_sel_e;

    typedef enum logic [1:0] {
        ST_LOAD = 2'd0,
        ST_IDLE = 2'd1,
        ST_RESP = 2'd2
    } irm_state_e;
endpackage

// File: rtl/irm_decode.sv
module irm_decode
    import irm_pkg::*;
#(
    parameter int ADDR_W   = 8,
    parameter int EXT_W    = 4,
    parameter int CAS_CODE = 2
) (
    input  logic [1:0]        kind,
    input  logic [ADDR_W-1:0] addr,
    input  logic [EXT_W-1:0]  ext,
    input  logic              wide,
    output rsp_code_e         code,
    output reg_sel_e          sel,
    output logic              lock_go
);
    logic in_window;
    logic aligned;

    assign in_window = (addr[ADDR_W-1:4] == '0);
    assign aligned   = (addr[1:0] == 2'b00);
    assign sel       = reg_sel_e'(addr[3:2]);

    always_comb begin
        code    = RC_DONE;
        lock_go = 1'b0;
        if (!aligned) begin
            code = RC_TYPE;
        end else if (!in_window) begin
            code = RC_ADDR;
        end else begin
            unique case (req_kind_e'(kind))
                K_READ:  code = RC_DONE;
                K_WRITE: code = RC_TYPE;
                K_RSVD:  code = RC_TYPE;
                K_LOCK: begin
                    if (ext != EXT_W'(CAS_CODE)) begin
                        code = RC_TYPE;
                    end else if (wide && (addr[3:2] != 2'(SEL_CHI))) begin
                        code = RC_TYPE;
                    end else begin
                        lock_go = 1'b1;
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/irm_bw_update.sv
module irm_bw_update #(
    parameter int REG_W = 32,
    parameter int BW_W  = 13
) (
    input  logic [BW_W-1:0]  cur,
    input  logic [REG_W-1:0] arg,
    input  logic [BW_W-1:0]  data,
    output logic [BW_W-1:0]  nxt,
    output logic [REG_W-1:0] ret
);
    localparam logic [REG_W-1:0] BW_LIMIT = REG_W'((1 << BW_W) - 1);

    logic [BW_W-1:0] a_lo;
    logic [BW_W-1:0] amount;
    logic [BW_W:0]   total;

    assign a_lo = arg[BW_W-1:0];

    always_comb begin
        nxt    = cur;
        ret    = REG_W'(cur);
        amount = '0;
        total  = '0;
        if (arg <= BW_LIMIT) begin
            if (a_lo >= data) begin
                amount = a_lo - data;
                if (cur >= amount) begin
                    nxt = cur - amount;
                    ret = arg;
                end
            end else begin
                amount = data - a_lo;
                total  = {1'b0, cur} + {1'b0, amount};
                if (!total[BW_W]) begin
                    nxt = total[BW_W-1:0];
                    ret = arg;
                end
            end
        end
    end
endmodule

// File: rtl/irm_chan_update.sv
module irm_chan_update #(
    parameter int W = 32
) (
    input  logic [W-1:0] cur,
    input  logic [W-1:0] arg,
    input  logic [W-1:0] data,
    output logic [W-1:0] nxt,
    output logic [W-1:0] ret
);
    logic [W-1:0] flip;
    logic         agree;

    assign flip  = arg ^ data;
    assign agree = ((arg & flip) == (cur & flip));
    assign nxt   = agree ? (cur ^ flip) : cur;
    assign ret   = agree ? arg : cur;
endmodule

// File: rtl/irm_lock_regs.sv
module irm_lock_regs
    import irm_pkg::*;
#(
    parameter int                 ADDR_W   = 8,
    parameter int                 EXT_W    = 4,
    parameter int                 CAS_CODE = 2,
    parameter int                 REG_W    = 32,
    parameter int                 BW_W     = 13,
    parameter logic [31:0]        BM_DEF   = 32'h0000_003F,
    parameter int                 BW_DEF   = 4915,
    parameter logic [31:0]        CHI_DEF  = 32'hFFFF_FFFE,
    parameter logic [31:0]        CLO_DEF  = 32'hFFFF_FFFF
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_reset,
    input  logic                 req_valid,
    input  logic [1:0]           req_kind,
    input  logic [ADDR_W-1:0]    req_addr,
    input  logic [EXT_W-1:0]     req_ext,
    input  logic                 req_wide,
    input  logic [2*REG_W-1:0]   req_arg,
    input  logic [2*REG_W-1:0]   req_data,
    output logic                 rsp_valid,
    output logic [1:0]           rsp_code,
    output logic [2*REG_W-1:0]   rsp_old
);
    localparam int WW = 2 * REG_W;
    localparam logic [REG_W-1:0] BCAST_BIT = REG_W'(1);

    irm_state_e      state_q, state_d;
    logic [REG_W-1:0] bm_q, chi_q, clo_q;
    logic [BW_W-1:0]  bw_q;
    logic [WW-1:0]    old_q;
    rsp_code_e        code_q;

    rsp_code_e        dec_code;
    reg_sel_e         sel;
    logic             lock_go;

    logic [REG_W-1:0] arg32, data32;
    logic [REG_W-1:0] c32_cur, c32_data, c32_nxt, c32_ret;
    logic [WW-1:0]    c64_data, c64_nxt, c64_ret;
    logic [BW_W-1:0]  bw_nxt;
    logic [REG_W-1:0] bw_ret;
    logic [REG_W-1:0] read_val;
    logic [WW-1:0]    old_d;

    assign arg32  = req_arg[REG_W-1:0];
    assign data32 = req_data[REG_W-1:0];

    irm_decode #(.ADDR_W(ADDR_W), .EXT_W(EXT_W), .CAS_CODE(CAS_CODE)) u_decode (
        .kind    (req_kind),
        .addr    (req_addr),
        .ext     (req_ext),
        .wide    (req_wide),
        .code    (dec_code),
        .sel     (sel),
        .lock_go (lock_go)
    );

    irm_bw_update #(.REG_W(REG_W), .BW_W(BW_W)) u_bw (
        .cur  (bw_q),
        .arg  (arg32),
        .data (data32[BW_W-1:0]),
        .nxt  (bw_nxt),
        .ret  (bw_ret)
    );

    // Broadcast channel protection: never let a lock free bit 0 of high word
    assign c32_cur  = (sel == SEL_CLO) ? clo_q : chi_q;
    assign c32_data = (sel == SEL_CHI) ? (data32 & ~BCAST_BIT) : data32;
    assign c64_data = req_data & ~({BCAST_BIT, {REG_W{1'b0}}});

    irm_chan_update #(.W(REG_W)) u_chan32 (
        .cur  (c32_cur),
        .arg  (arg32),
        .data (c32_data),
        .nxt  (c32_nxt),
        .ret  (c32_ret)
    );

    irm_chan_update #(.W(WW)) u_chan64 (
        .cur  ({chi_q, clo_q}),
        .arg  (req_arg),
        .data (c64_data),
        .nxt  (c64_nxt),
        .ret  (c64_ret)
    );

    always_comb begin
        unique case (sel)
            SEL_BM:  read_val = bm_q;
            SEL_BW:  read_val = REG_W'(bw_q);
            SEL_CHI: read_val = chi_q;
            SEL_CLO: read_val = clo_q;
        endcase
    end

    always_comb begin
        old_d = '0;
        if (dec_code == RC_DONE) begin
            if (!lock_go) begin
                old_d = WW'(read_val);
            end else if (req_wide) begin
                old_d = c64_ret;
            end else begin
                unique case (sel)
                    SEL_BM:  old_d = WW'(bm_q);
                    SEL_BW:  old_d = WW'(bw_ret);
                    SEL_CHI: old_d = WW'(c32_ret);
                    SEL_CLO: old_d = WW'(c32_ret);
                endcase
            end
        end
    end

    // Next-state logic
    always_comb begin
        if (bus_reset)       state_d = ST_LOAD;
        else if (req_valid)  state_d = ST_RESP;
        else                 state_d = ST_IDLE;
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_LOAD;
        else        state_q <= state_d;
    end

    // Outputs and resource registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bm_q   <= BM_DEF;
            bw_q   <= BW_W'(BW_DEF);
            chi_q  <= CHI_DEF;
            clo_q  <= CLO_DEF;
            old_q  <= '0;
            code_q <= RC_DONE;
        end else if (state_d == ST_LOAD) begin
            bm_q   <= BM_DEF;
            bw_q   <= BW_W'(BW_DEF);
            chi_q  <= CHI_DEF;
            clo_q  <= CLO_DEF;
            old_q  <= '0;
            code_q <= RC_DONE;
        end else if (state_d == ST_RESP) begin
            old_q  <= old_d;
            code_q <= dec_code;
            if (lock_go) begin
                if (req_wide) begin
                    chi_q <= c64_nxt[WW-1:REG_W];
                    clo_q <= c64_nxt[REG_W-1:0];
                end else begin
                    unique case (sel)
                        SEL_BM:  if (bm_q == arg32) bm_q <= data32;
                        SEL_BW:  bw_q  <= bw_nxt;
                        SEL_CHI: chi_q <= c32_nxt;
                        SEL_CLO: clo_q <= c32_nxt;
                    endcase
                end
            end
        end
    end

    assign rsp_valid = (state_q == ST_RESP);
    assign rsp_code  = code_q;
    assign rsp_old   = old_q;

    // R1: defaults present after a bus reset cycle
    a_r1_defaults: assert property (@(posedge clk) disable iff (!rst_n)
        $past(bus_reset) |-> (bm_q == BM_DEF && bw_q == BW_W'(BW_DEF)
                              && chi_q == CHI_DEF && clo_q == CLO_DEF));

    // R2: request answered in the next cycle; no answer without one
    a_r2_resp_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !bus_reset) |=> rsp_valid);
    a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_valid || bus_reset) |=> !rsp_valid);

    // R8: broadcast channel always allocated
    a_r8_bcast_held: assert property (@(posedge clk) disable iff (!rst_n)
        chi_q[0] == 1'b0);

    // R10: non-lock requests leave every register untouched
    a_r10_nonlock_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !bus_reset && req_kind != 2'(K_LOCK)) |=>
        ($stable(bm_q) && $stable(bw_q) && $stable(chi_q) && $stable(clo_q)));

    // R11: error responses carry a zero old value
    a_r11_err_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_code != 2'(RC_DONE)) |-> (rsp_old == '0));
endmodule

// File: tb/test_irm_lock_regs.sv
module test_irm_lock_regs;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_reset = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_kind = '0;
    logic [7:0]  req_addr = '0;
    logic [3:0]  req_ext = '0;
    logic        req_wide = 1'b0;
    logic [63:0] req_arg = '0;
    logic [63:0] req_data = '0;
    logic        rsp_valid;
    logic [1:0]  rsp_code;
    logic [63:0] rsp_old;

    int n_run = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    irm_lock_regs i_irm_lock_regs (
        .clk(clk), .rst_n(rst_n), .bus_reset(bus_reset),
        .req_valid(req_valid), .req_kind(req_kind), .req_addr(req_addr),
        .req_ext(req_ext), .req_wide(req_wide), .req_arg(req_arg),
        .req_data(req_data), .rsp_valid(rsp_valid), .rsp_code(rsp_code),
        .rsp_old(rsp_old)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic req(input string tag, input logic [1:0] kind, input logic [7:0] addr,
                       input logic [3:0] ext, input logic wide,
                       input logic [63:0] arg, input logic [63:0] data,
                       input logic [1:0] exp_code, input logic [63:0] exp_old);
        @(negedge clk);
        req_valid = 1'b1; req_kind = kind; req_addr = addr; req_ext = ext;
        req_wide = wide; req_arg = arg; req_data = data;
        @(posedge clk); #1;
        chk({tag, " valid"}, 64'(rsp_valid), 64'd1);
        chk({tag, " code"}, 64'(rsp_code), 64'(exp_code));
        chk({tag, " old"}, rsp_old, exp_old);
        @(negedge clk);
        req_valid = 1'b0; req_wide = 1'b0;
        @(posedge clk); #1;
        chk({tag, " strobe width"}, 64'(rsp_valid), 64'd0);
    endtask

    task automatic rd(input string tag, input logic [7:0] addr, input logic [31:0] exp);
        req(tag, 2'd0, addr, 4'd0, 1'b0, 64'd0, 64'd0, 2'd0, 64'(exp));
    endtask

    task automatic lk(input string tag, input logic [7:0] addr, input logic [31:0] arg,
                      input logic [31:0] data, input logic [31:0] exp_old);
        req(tag, 2'd2, addr, 4'd2, 1'b0, 64'(arg), 64'(data), 2'd0, 64'(exp_old));
    endtask

    task automatic t_reset;
        chk("R2 idle after reset", 64'(rsp_valid), 64'd0);
        rd("R1 bm default", 8'h0, 32'h3F);
        rd("R1 bw default", 8'h4, 32'd4915);
        rd("R1 chi default", 8'h8, 32'hFFFF_FFFE);
        rd("R1 clo default", 8'hC, 32'hFFFF_FFFF);
    endtask

    task automatic t_bus_manager;
        lk("R3 swap hit", 8'h0, 32'h3F, 32'h05, 32'h3F);
        rd("R3 bm now 5", 8'h0, 32'h05);
        lk("R3 swap miss", 8'h0, 32'h3F, 32'h07, 32'h05);
        rd("R3 bm kept 5", 8'h0, 32'h05);
    endtask

    task automatic t_bandwidth;
        lk("R4 arg too big", 8'h4, 32'h2000, 32'h0, 32'd4915);
        rd("R4 bw unchanged", 8'h4, 32'd4915);
        lk("R5 alloc 100", 8'h4, 32'd4915, 32'd4815, 32'd4915);
        rd("R5 bw 4815", 8'h4, 32'd4815);
        lk("R5 alloc too much", 8'h4, 32'd5000, 32'd0, 32'd4815);
        rd("R5 bw kept", 8'h4, 32'd4815);
        lk("R4 data masked", 8'h4, 32'd4815, 32'hFFFF_E000 | 32'd4715, 32'd4815);
        rd("R4 bw 4715", 8'h4, 32'd4715);
        lk("R6 release 100", 8'h4, 32'd4715, 32'd4815, 32'd4715);
        rd("R6 bw 4815", 8'h4, 32'd4815);
        lk("R6 release overflow", 8'h4, 32'd0, 32'h1FFF, 32'd4815);
        rd("R6 bw kept", 8'h4, 32'd4815);
        lk("R6 release to limit", 8'h4, 32'd0, 32'd3376, 32'd0);
        rd("R6 bw at 0x1FFF", 8'h4, 32'h1FFF);
    endtask

    task automatic t_channels;
        lk("R7 alloc ch", 8'hC, 32'hFFFF_FFFF, 32'hFFFF_FFDF, 32'hFFFF_FFFF);
        rd("R7 clo bit5 clear", 8'hC, 32'hFFFF_FFDF);
        lk("R7 double alloc", 8'hC, 32'hFFFF_FFFF, 32'hFFFF_FFDF, 32'hFFFF_FFDF);
        rd("R7 clo kept", 8'hC, 32'hFFFF_FFDF);
        lk("R7 free ch", 8'hC, 32'hFFFF_FFDF, 32'hFFFF_FFFF, 32'hFFFF_FFDF);
        rd("R7 clo restored", 8'hC, 32'hFFFF_FFFF);
    endtask

    task automatic t_broadcast;
        lk("R8 free bcast", 8'h8, 32'hFFFF_FFFE, 32'hFFFF_FFFF, 32'hFFFF_FFFE);
        rd("R8 chi still held", 8'h8, 32'hFFFF_FFFE);
        lk("R8 mixed", 8'h8, 32'hFFFF_FFFE, 32'hFFFF_FFFD, 32'hFFFF_FFFE);
        rd("R8 chi bit1 taken", 8'h8, 32'hFFFF_FFFC);
    endtask

    task automatic t_wide;
        req("R9 wide hit", 2'd2, 8'h8, 4'd2, 1'b1,
            {32'hFFFF_FFFC, 32'hFFFF_FFFF}, {32'hFFFF_FFFD, 32'hFFFF_FFF0},
            2'd0, {32'hFFFF_FFFC, 32'hFFFF_FFFF});
        rd("R9 chi after wide", 8'h8, 32'hFFFF_FFFC);
        rd("R9 clo after wide", 8'hC, 32'hFFFF_FFF0);
        req("R9 wide miss", 2'd2, 8'h8, 4'd2, 1'b1,
            {32'hFFFF_FFFC, 32'hFFFF_FFFF}, {32'hFFFF_FFFC, 32'hFFFF_FFF0},
            2'd0, {32'hFFFF_FFFC, 32'hFFFF_FFF0});
        req("R9 wide at 0xC", 2'd2, 8'hC, 4'd2, 1'b1, 64'd0, 64'd1, 2'd1, 64'd0);
        req("R9 wide at 0x0", 2'd2, 8'h0, 4'd2, 1'b1, 64'h5, 64'h1, 2'd1, 64'd0);
        rd("R9 bm untouched", 8'h0, 32'h05);
    endtask

    task automatic t_access;
        req("R10 write bm", 2'd1, 8'h0, 4'd0, 1'b0, 64'd0, 64'd0, 2'd1, 64'd0);
        rd("R10 bm unchanged", 8'h0, 32'h05);
        req("R11 write outside", 2'd1, 8'h20, 4'd0, 1'b0, 64'd0, 64'd0, 2'd2, 64'd0);
        req("R11 read outside", 2'd0, 8'h10, 4'd0, 1'b0, 64'd0, 64'd0, 2'd2, 64'd0);
        req("R11 unaligned", 2'd2, 8'h2, 4'd2, 1'b0, 64'h5, 64'h1, 2'd1, 64'd0);
        req("R11 bad ext", 2'd2, 8'h4, 4'd1, 1'b0, 64'h1FFF, 64'd0, 2'd1, 64'd0);
        rd("R11 bw unchanged", 8'h4, 32'h1FFF);
        req("R11 lock outside", 2'd2, 8'h10, 4'd2, 1'b0, 64'd0, 64'd0, 2'd2, 64'd0);
        req("R11 reserved kind", 2'd3, 8'h0, 4'd2, 1'b0, 64'h5, 64'h9, 2'd1, 64'd0);
        rd("R11 bm unchanged", 8'h0, 32'h05);
    endtask

    task automatic t_bus_reset;
        @(negedge clk);
        bus_reset = 1'b1; req_valid = 1'b1; req_kind = 2'd2; req_addr = 8'h0;
        req_ext = 4'd2; req_arg = 64'h5; req_data = 64'h9;
        @(posedge clk); #1;
        chk("R2 dropped during bus reset", 64'(rsp_valid), 64'd0);
        @(negedge clk);
        bus_reset = 1'b0; req_valid = 1'b0;
        rd("R1 bm after bus reset", 8'h0, 32'h3F);
        rd("R1 bw after bus reset", 8'h4, 32'd4915);
        rd("R1 chi after bus reset", 8'h8, 32'hFFFF_FFFE);
        rd("R1 clo after bus reset", 8'hC, 32'hFFFF_FFFF);
    endtask

    initial begin
        #400000;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk); #1;
        t_reset();
        t_bus_manager();
        t_bandwidth();
        t_channels();
        t_broadcast();
        t_wide();
        t_access();
        t_bus_reset();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule